// File: doc/BRIEF.md
# Integer Out-of-Order Issue Queue

This block holds renamed integer instructions until their source operands become available, then sends them to two execution pipes. It has sixteen slots and keeps no program order among them. A new instruction goes into a free slot. Its two operand-ready flags are loaded from the busy state that the rename stage looks up for its physical source registers. Each slot compares its stored source tags against the destination tags that two result ports broadcast. A matching tag marks that operand as available.

Each cycle a selector looks at the occupied slots whose operands are both available and offers up to two of them, one to each execution pipe. Pipe 0 is the only pipe that accepts shift and branch-condition operations. Pipe 1 is the only pipe that accepts multiply and divide. Plain ALU operations may go to either pipe. A slot is released in the same cycle its instruction is accepted by a pipe, not at graduation.

The dispatch input and both issue outputs are valid/ready streams. On dispatch, the queue raises `disp_ready` whenever a slot is free, and a transfer happens only when `disp_valid` and `disp_ready` are both high. On issue, the queue holds `issN_valid` and its payload until the pipe raises `issN_ready`. While a pipe stalls, its offer can move to a lower-numbered slot that becomes eligible, because the selection is made again every cycle. The result broadcasts and `flush` are plain control inputs.

Top module: `int_issue_queue`

## Requirements
- R1: The queue holds 16 instructions. `disp_ready` is high exactly when at least one slot is free and `flush` is low, so after 16 accepted dispatches without any issue, `disp_ready` is low.
- R2: An accepted dispatch is written into the lowest-numbered free slot. A `disp_valid` while `disp_ready` is low is ignored and creates no entry.
- R3: When an instruction is written, a source operand whose busy input is 0 is marked available.
- R4: A result broadcast with valid high and a tag equal to a stored source tag marks that operand available. The instruction can be offered for issue in the cycle after the broadcast.
- R5: A broadcast in the same cycle as the dispatch also marks the matching operands of the instruction being written as available.
- R6: An instruction is offered on an issue port only when both of its operands are available.
- R7: Class encoding is 2'b00 for ALU (either pipe), 2'b01 for shift/branch (pipe 0 only) and 2'b10 for multiply/divide (pipe 1 only).
- R8: Each pipe is offered the lowest-numbered eligible slot of a class it accepts. Pipe 1 never gets the slot offered to pipe 0.
- R9: A slot is freed in the cycle its issue handshake completes. An offer that is not accepted keeps its slot occupied.
- R10: `flush` empties the queue from the next cycle on. During the flush cycle no dispatch is accepted and no issue is offered.
- R11: After reset the queue is empty: `disp_ready` is high and both issue valids are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard all queued instructions |
| disp_valid | input | 1 | Dispatch request |
| disp_ready | output | 1 | Queue can accept a dispatch |
| disp_src0 | input | 6 | Physical tag of source 0 |
| disp_src1 | input | 6 | Physical tag of source 1 |
| disp_src0_busy | input | 1 | Source 0 not yet produced |
| disp_src1_busy | input | 1 | Source 1 not yet produced |
| disp_dst | input | 6 | Physical destination tag |
| disp_cls | input | 2 | Operation class |
| disp_atag | input | 5 | In-flight instruction identifier |
| wb0_valid | input | 1 | Result broadcast 0 valid |
| wb0_tag | input | 6 | Result broadcast 0 destination tag |
| wb1_valid | input | 1 | Result broadcast 1 valid |
| wb1_tag | input | 6 | Result broadcast 1 destination tag |
| iss0_valid | output | 1 | Instruction offered to pipe 0 |
| iss0_ready | input | 1 | Pipe 0 accepts |
| iss0_src0 | output | 6 | Source 0 tag for pipe 0 |
| iss0_src1 | output | 6 | Source 1 tag for pipe 0 |
| iss0_dst | output | 6 | Destination tag for pipe 0 |
| iss0_cls | output | 2 | Class for pipe 0 |
| iss0_atag | output | 5 | Identifier for pipe 0 |
| iss1_valid | output | 1 | Instruction offered to pipe 1 |
| iss1_ready | input | 1 | Pipe 1 accepts |
| iss1_src0 | output | 6 | Source 0 tag for pipe 1 |
| iss1_src1 | output | 6 | Source 1 tag for pipe 1 |
| iss1_dst | output | 6 | Destination tag for pipe 1 |
| iss1_cls | output | 2 | Class for pipe 1 |
| iss1_atag | output | 5 | Identifier for pipe 1 |

## Verification
A slot whose valid flag is stuck or lost shows up in two ways: `disp_ready` takes the wrong level, or an instruction issues twice or never issues. Either symptom appears the first time the queue fills or the slot would be selected. A missed wakeup delays an issue by at least one cycle against the expected offer. A false wakeup offers an instruction whose operands are still busy. Both are visible on the issue ports in the cycle after the broadcast. Selection or routing faults show as a wrong identifier or class on an issue port in the very cycle of the offer.

// File: rtl/iq_pkg.sv
package iq_pkg;
  localparam int TAG_W = 6;
  localparam int AL_W  = 5;
  localparam int CLS_W = 2;

  typedef enum logic [CLS_W-1:0] {
    CLS_ALU = 2'b00,
    CLS_SHB = 2'b01,
    CLS_MDV = 2'b10
  } op_cls_e;

  typedef struct packed {
    logic [TAG_W-1:0] src0;
    logic [TAG_W-1:0] src1;
    logic [TAG_W-1:0] dst;
    op_cls_e          cls;
    logic [AL_W-1:0]  atag;
  } iq_payload_t;
endpackage

// File: rtl/iq_pick.sv
module iq_pick #(
  parameter  int N  = 16,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/iq_slot.sv
module iq_slot
  import iq_pkg::*;
#(
  parameter int NWB = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      flush,
  input  logic                      wr_en,
  input  iq_payload_t               wr_pl,
  input  logic                      wr_busy0,
  input  logic                      wr_busy1,
  input  logic [NWB-1:0]            wb_vld,
  input  logic [NWB-1:0][TAG_W-1:0] wb_tag,
  input  logic                      clr,
  output logic                      vld,
  output iq_payload_t               pl,
  output logic                      rdy0,
  output logic                      rdy1
);
  logic hit0, hit1, nhit0, nhit1;

  always_comb begin
    hit0  = 1'b0;
    hit1  = 1'b0;
    nhit0 = 1'b0;
    nhit1 = 1'b0;
    for (int w = 0; w < NWB; w++) begin
      if (wb_vld[w] && wb_tag[w] == pl.src0)    hit0  = 1'b1;
      if (wb_vld[w] && wb_tag[w] == pl.src1)    hit1  = 1'b1;
      if (wb_vld[w] && wb_tag[w] == wr_pl.src0) nhit0 = 1'b1;
      if (wb_vld[w] && wb_tag[w] == wr_pl.src1) nhit1 = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      vld  <= 1'b0;
      rdy0 <= 1'b0;
      rdy1 <= 1'b0;
      pl   <= '0;
    end else if (clr) begin
      vld  <= 1'b0;
      rdy0 <= 1'b0;
      rdy1 <= 1'b0;
    end else if (wr_en) begin
      vld  <= 1'b1;
      pl   <= wr_pl;
      rdy0 <= !wr_busy0 || nhit0;
      rdy1 <= !wr_busy1 || nhit1;
    end else if (vld) begin
      rdy0 <= rdy0 || hit0;
      rdy1 <= rdy1 || hit1;
    end
  end

  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !vld);  // R2
  AST_SLOT_FREED: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !flush) |=> !vld);  // R9
  AST_WAKE0: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && hit0 && !clr && !flush) |=> rdy0);  // R4
  AST_WAKE1: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && hit1 && !clr && !flush) |=> rdy1);  // R4
  AST_WAKE_AT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !flush && nhit0 && nhit1) |=> (rdy0 && rdy1));  // R5
endmodule

// File: rtl/int_issue_queue.sv
module int_issue_queue
  import iq_pkg::*;
#(
  parameter  int DEPTH = 16,
  localparam int IW    = $clog2(DEPTH),
  localparam int NWB   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             disp_valid,
  output logic             disp_ready,
  input  logic [TAG_W-1:0] disp_src0,
  input  logic [TAG_W-1:0] disp_src1,
  input  logic             disp_src0_busy,
  input  logic             disp_src1_busy,
  input  logic [TAG_W-1:0] disp_dst,
  input  logic [CLS_W-1:0] disp_cls,
  input  logic [AL_W-1:0]  disp_atag,
  input  logic             wb0_valid,
  input  logic [TAG_W-1:0] wb0_tag,
  input  logic             wb1_valid,
  input  logic [TAG_W-1:0] wb1_tag,
  output logic             iss0_valid,
  input  logic             iss0_ready,
  output logic [TAG_W-1:0] iss0_src0,
  output logic [TAG_W-1:0] iss0_src1,
  output logic [TAG_W-1:0] iss0_dst,
  output logic [CLS_W-1:0] iss0_cls,
  output logic [AL_W-1:0]  iss0_atag,
  output logic             iss1_valid,
  input  logic             iss1_ready,
  output logic [TAG_W-1:0] iss1_src0,
  output logic [TAG_W-1:0] iss1_src1,
  output logic [TAG_W-1:0] iss1_dst,
  output logic [CLS_W-1:0] iss1_cls,
  output logic [AL_W-1:0]  iss1_atag
);
  logic [DEPTH-1:0]          s_vld, s_rdy0, s_rdy1, s_wr, s_clr;
  iq_payload_t               s_pl [DEPTH];
  logic [DEPTH-1:0]          elig0, elig1, elig1_m;
  logic [NWB-1:0]            wb_vld;
  logic [NWB-1:0][TAG_W-1:0] wb_tag;
  iq_payload_t               new_pl;
  logic                      free_found, f0, f1;
  logic [IW-1:0]             free_idx, idx0, idx1;
  iq_payload_t               pl0, pl1;

  assign wb_vld = {wb1_valid, wb0_valid};
  assign wb_tag = {wb1_tag, wb0_tag};

  always_comb begin
    new_pl.src0 = disp_src0;
    new_pl.src1 = disp_src1;
    new_pl.dst  = disp_dst;
    new_pl.cls  = op_cls_e'(disp_cls);
    new_pl.atag = disp_atag;
  end

  iq_pick #(.N(DEPTH)) u_free (.req(~s_vld), .found(free_found), .idx(free_idx));

  assign disp_ready = free_found && !flush;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    assign s_wr[g] = disp_valid && disp_ready && (free_idx == IW'(g));
    assign s_clr[g] = (iss0_valid && iss0_ready && idx0 == IW'(g)) ||
                      (iss1_valid && iss1_ready && idx1 == IW'(g));
    assign elig0[g] = s_vld[g] && s_rdy0[g] && s_rdy1[g] && (s_pl[g].cls != CLS_MDV);
    assign elig1[g] = s_vld[g] && s_rdy0[g] && s_rdy1[g] && (s_pl[g].cls != CLS_SHB);

    iq_slot #(.NWB(NWB)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (flush),
      .wr_en   (s_wr[g]),
      .wr_pl   (new_pl),
      .wr_busy0(disp_src0_busy),
      .wr_busy1(disp_src1_busy),
      .wb_vld  (wb_vld),
      .wb_tag  (wb_tag),
      .clr     (s_clr[g]),
      .vld     (s_vld[g]),
      .pl      (s_pl[g]),
      .rdy0    (s_rdy0[g]),
      .rdy1    (s_rdy1[g])
    );
  end

  iq_pick #(.N(DEPTH)) u_pick0 (.req(elig0), .found(f0), .idx(idx0));

  assign elig1_m = elig1 & ~({{(DEPTH-1){1'b0}}, f0} << idx0);

  iq_pick #(.N(DEPTH)) u_pick1 (.req(elig1_m), .found(f1), .idx(idx1));

  assign pl0 = s_pl[idx0];
  assign pl1 = s_pl[idx1];

  assign iss0_valid = f0 && !flush;
  assign iss0_src0  = pl0.src0;
  assign iss0_src1  = pl0.src1;
  assign iss0_dst   = pl0.dst;
  assign iss0_cls   = pl0.cls;
  assign iss0_atag  = pl0.atag;

  assign iss1_valid = f1 && !flush;
  assign iss1_src0  = pl1.src0;
  assign iss1_src1  = pl1.src1;
  assign iss1_dst   = pl1.dst;
  assign iss1_cls   = pl1.cls;
  assign iss1_atag  = pl1.atag;

  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (&s_vld) |-> !disp_ready);  // R1
  AST_DISTINCT_PICK: assert property (@(posedge clk) disable iff (!rst_n)
    (iss0_valid && iss1_valid) |-> (idx0 != idx1));  // R8
  AST_ROUTE_P0: assert property (@(posedge clk) disable iff (!rst_n)
    iss0_valid |-> (iss0_cls != CLS_MDV));  // R7
  AST_ROUTE_P1: assert property (@(posedge clk) disable iff (!rst_n)
    iss1_valid |-> (iss1_cls != CLS_SHB));  // R7
  AST_ISSUE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    iss0_valid |-> (s_vld[idx0] && s_rdy0[idx0] && s_rdy1[idx0]));  // R6
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (s_vld == '0));  // R10
  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(s_wr));  // R2
endmodule

// File: tb/int_issue_queue_bench.sv
module int_issue_queue_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic disp_valid = 1'b0, disp_ready;
  logic [5:0] disp_src0 = '0, disp_src1 = '0, disp_dst = '0;
  logic disp_src0_busy = 1'b0, disp_src1_busy = 1'b0;
  logic [1:0] disp_cls = '0;
  logic [4:0] disp_atag = '0;
  logic wb0_valid = 1'b0, wb1_valid = 1'b0;
  logic [5:0] wb0_tag = '0, wb1_tag = '0;
  logic iss0_valid, iss1_valid;
  logic iss0_ready = 1'b1, iss1_ready = 1'b1;
  logic [5:0] iss0_src0, iss0_src1, iss0_dst, iss1_src0, iss1_src1, iss1_dst;
  logic [1:0] iss0_cls, iss1_cls;
  logic [4:0] iss0_atag, iss1_atag;

  int total = 0, fails = 0;
  bit done = 1'b0;
  int atag_cnt = 0;

  bit         m_v  [16];
  bit         m_r0 [16];
  bit         m_r1 [16];
  logic [5:0] m_s0 [16];
  logic [5:0] m_s1 [16];
  logic [5:0] m_d  [16];
  logic [1:0] m_c  [16];
  logic [4:0] m_a  [16];

  always #2 clk = ~clk;

  int_issue_queue u_int_issue_queue (.*);

  task automatic chk(input string ph, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", ph, what, act, exp);
    end
  endtask

  function automatic bit wb_hit(input logic [5:0] t);
    return (wb0_valid && wb0_tag == t) || (wb1_valid && wb1_tag == t);
  endfunction

  function automatic int pick(input int unit, input int excl);
    for (int i = 0; i < 16; i++)
      if (m_v[i] && m_r0[i] && m_r1[i] && i != excl &&
          ((unit == 0) ? (m_c[i] != 2'b10) : (m_c[i] != 2'b01)))
        return i;
    return -1;
  endfunction

  task automatic tick(input string ph);
    int fr, p0, p1;
    bit edr;
    #1;
    fr = -1;
    for (int i = 15; i >= 0; i--) if (!m_v[i]) fr = i;
    edr = (fr >= 0) && !flush;
    p0 = pick(0, -1);
    p1 = pick(1, p0);
    chk(ph, "disp_ready", int'(disp_ready), int'(edr));
    chk(ph, "iss0_valid", int'(iss0_valid), int'(p0 >= 0 && !flush));
    chk(ph, "iss1_valid", int'(iss1_valid), int'(p1 >= 0 && !flush));
    if (p0 >= 0 && !flush && iss0_valid) begin
      chk(ph, "iss0_atag", int'(iss0_atag), int'(m_a[p0]));
      chk(ph, "iss0_dst", int'(iss0_dst), int'(m_d[p0]));
      chk(ph, "iss0_cls", int'(iss0_cls), int'(m_c[p0]));
      chk(ph, "iss0_src0", int'(iss0_src0), int'(m_s0[p0]));
    end
    if (p1 >= 0 && !flush && iss1_valid) begin
      chk(ph, "iss1_atag", int'(iss1_atag), int'(m_a[p1]));
      chk(ph, "iss1_dst", int'(iss1_dst), int'(m_d[p1]));
      chk(ph, "iss1_cls", int'(iss1_cls), int'(m_c[p1]));
      chk(ph, "iss1_src1", int'(iss1_src1), int'(m_s1[p1]));
    end
    if (flush) begin
      for (int i = 0; i < 16; i++) m_v[i] = 1'b0;
    end else begin
      if (p0 >= 0 && iss0_ready) m_v[p0] = 1'b0;
      if (p1 >= 0 && iss1_ready) m_v[p1] = 1'b0;
      for (int i = 0; i < 16; i++) if (m_v[i]) begin
        if (wb_hit(m_s0[i])) m_r0[i] = 1'b1;
        if (wb_hit(m_s1[i])) m_r1[i] = 1'b1;
      end
      if (disp_valid && edr) begin
        m_v[fr]  = 1'b1;
        m_s0[fr] = disp_src0;
        m_s1[fr] = disp_src1;
        m_d[fr]  = disp_dst;
        m_c[fr]  = disp_cls;
        m_a[fr]  = disp_atag;
        m_r0[fr] = !disp_src0_busy || wb_hit(disp_src0);
        m_r1[fr] = !disp_src1_busy || wb_hit(disp_src1);
      end
    end
    @(negedge clk);
  endtask

  task automatic idle();
    disp_valid = 1'b0;
    wb0_valid = 1'b0;
    wb1_valid = 1'b0;
    flush = 1'b0;
  endtask

  task automatic put(input logic [5:0] s0, input logic [5:0] s1, input bit b0,
                     input bit b1, input logic [1:0] cls);
    disp_valid = 1'b1;
    disp_src0 = s0;
    disp_src1 = s1;
    disp_src0_busy = b0;
    disp_src1_busy = b1;
    disp_cls = cls;
    disp_dst = 6'($urandom % 64);
    disp_atag = 5'(atag_cnt);
    atag_cnt++;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL R1..all watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 16; i++) m_v[i] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    idle();
    tick("R11");

    put(6'd1, 6'd2, 1'b0, 1'b0, 2'b00);
    tick("R3");
    idle();
    tick("R3");

    iss0_ready = 1'b0;
    iss1_ready = 1'b0;
    for (int k = 0; k < 18; k++) begin
      put(6'd40, 6'd40, 1'b1, 1'b1, 2'(k % 3));
      tick((k < 16) ? "R1" : "R2");
    end
    idle();
    chk("R1", "disp_ready_full", int'(disp_ready), 0);
    tick("R2");

    wb0_valid = 1'b1;
    wb0_tag = 6'd40;
    tick("R4");
    idle();
    tick("R4");
    for (int k = 0; k < 14; k++) begin
      iss0_ready = k[0];
      iss1_ready = k[1];
      tick("R9");
    end
    iss0_ready = 1'b1;
    iss1_ready = 1'b1;
    repeat (12) tick("R9");

    put(6'd41, 6'd42, 1'b1, 1'b1, 2'b00);
    wb0_valid = 1'b1;
    wb0_tag = 6'd41;
    wb1_valid = 1'b1;
    wb1_tag = 6'd42;
    tick("R5");
    idle();
    tick("R5");

    put(6'd3, 6'd3, 1'b0, 1'b0, 2'b01);
    tick("R7");
    put(6'd3, 6'd3, 1'b0, 1'b0, 2'b01);
    tick("R7");
    put(6'd4, 6'd4, 1'b0, 1'b0, 2'b10);
    tick("R7");
    idle();
    repeat (4) tick("R7");

    iss0_ready = 1'b0;
    iss1_ready = 1'b0;
    for (int k = 0; k < 5; k++) begin
      put(6'd5, 6'd6, 1'b0, 1'b0, 2'b00);
      tick("R10");
    end
    idle();
    put(6'd5, 6'd6, 1'b0, 1'b0, 2'b00);
    flush = 1'b1;
    tick("R10");
    idle();
    iss0_ready = 1'b1;
    iss1_ready = 1'b1;
    chk("R10", "iss0_after_flush", int'(iss0_valid), 0);
    tick("R10");

    for (int k = 0; k < 4000; k++) begin
      disp_valid = ($urandom % 10) < 6;
      if (disp_valid)
        put(6'($urandom % 8), 6'($urandom % 8), 1'($urandom % 2), 1'($urandom % 2),
            2'($urandom % 3));
      wb0_valid = ($urandom % 2) == 0;
      wb0_tag = 6'($urandom % 8);
      wb1_valid = ($urandom % 3) == 0;
      wb1_tag = 6'($urandom % 8);
      iss0_ready = ($urandom % 4) != 0;
      iss1_ready = ($urandom % 4) != 0;
      flush = ($urandom % 250) == 0;
      tick("R6/R8");
    end
    idle();
    repeat (4) tick("R8");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule